// File: doc/BRIEF.md
# PCI BAR Size Decoder

This block turns the results of PCI base address register sizing into two ready-made region lists, one for I/O space and one for memory space. For each register slot of a type-0 header, the host side supplies two 32-bit words on a valid/ready stream, one slot per beat. The first word is the value read back after writing all ones (the sizing readback). The second is the register's original contents. The block classifies the slot, computes the region length from the readback, checks that the readback has a legal mask shape, and appends valid slots to the matching list together with the base address.

A scan is a run of beats ending with a beat that has `in_last` set. The lists and their counts are cleared when the first beat of a new scan is accepted. They then hold their contents after the scan ends, so the system can read them at leisure through two registered index ports. A 64-bit memory register occupies two slots, so its upper half is consumed and discarded. Slots whose readback is malformed are dropped without trace. A one-cycle `scan_done` pulse marks the point at which the counts are final.

Top module: `bar_size_scan`

## Requirements
- R1: Bit 0 of the original register selects the list: 1 sends the slot to the I/O list, 0 to the memory list.
- R2: The length is the bitwise inverse of the masked readback plus one, taken modulo 2^32. The mask clears readback bits [1:0] for I/O and bits [3:0] for memory.
- R3: A slot is valid only when its (extended) readback is neither 0x00000000 nor 0xFFFFFFFF, and its inverted masked readback ANDed with that value plus one gives zero. An invalid slot writes no entry and leaves both counts unchanged.
- R4: The stored base is the original register with bits [1:0] cleared (I/O) or bits [3:0] cleared (memory).
- R5: An I/O readback whose bits [31:16] are all zero and whose bits [15:0] are not all zero is decoded as if bits [31:16] were ones.
- R6: A valid memory slot whose original bits [2:0] equal 3'b100 is 64-bit. The next accepted beat of the same scan is then ignored completely. An invalid slot with those type bits causes no skip, and a pending skip never carries into a new scan.
- R7: Each list holds LIST_DEPTH (default 6) entries. A valid slot arriving at a full list is dropped, and that list's overflow flag is set and held until the next scan starts.
- R8: Accepting the first beat of a scan (the first beat after reset, or the first after an `in_last` beat) clears both counts and both overflow flags before that beat's own entry is applied. Between scans, the counts, the flags and the entries stay unchanged.
- R9: `scan_done` is high for exactly one cycle, two rising edges after the edge that accepts an `in_last` beat. The counts and flags are already final in that cycle.
- R10: `in_ready` is always high. Entry `k` of a list appears on that list's base and length outputs one clock after `k` is presented on its index input.
- R11: While reset is held and after its release, both counts are 0, both overflow flags are 0 and `scan_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A register slot is offered this cycle |
| in_ready | output | 1 | Always 1; every offered slot is taken |
| in_sizing | input | 32 | Readback after writing all ones |
| in_orig | input | 32 | Original register contents |
| in_last | input | 1 | Marks the final slot of the scan |
| scan_done | output | 1 | One-cycle pulse when the scan's results are final |
| io_count | output | CNT_W | Number of entries in the I/O list |
| io_overflow | output | 1 | A valid I/O slot was dropped for lack of room |
| mem_count | output | CNT_W | Number of entries in the memory list |
| mem_overflow | output | 1 | A valid memory slot was dropped for lack of room |
| io_rd_idx | input | IDX_W | I/O list read index |
| io_rd_base | output | 32 | Base of the indexed I/O entry |
| io_rd_len | output | 32 | Length of the indexed I/O entry |
| mem_rd_idx | input | IDX_W | Memory list read index |
| mem_rd_base | output | 32 | Base of the indexed memory entry |
| mem_rd_len | output | 32 | Length of the indexed memory entry |

## Verification
The assertions assume that the stream is driven only from a reset state in which `in_valid` was low for at least two cycles. They relate `scan_done` and every count change to a beat accepted two edges earlier, so a beat offered during reset would break that link. They also assume that the read indices never ask for an entry beyond the count, because the contents of unwritten slots are unspecified. The stimulus keeps `in_valid` low throughout reset, changes inputs only on falling edges, and reads only indices below the count it expects. It sweeps every power-of-two I/O and memory size and adds scans that target extension, malformed masks, 64-bit skipping and overflow.

// File: rtl/bar_scan_pkg.sv
package bar_scan_pkg;

  localparam int BAR_W        = 32;
  localparam int HALF_W       = BAR_W / 2;
  localparam int IO_LOW_BITS  = 2;
  localparam int MEM_LOW_BITS = 4;
  localparam logic [2:0] MEM64_TYPE = 3'b100;

  typedef enum logic {
    SPACE_MEM = 1'b0,
    SPACE_IO  = 1'b1
  } bar_space_e;

  typedef struct packed {
    logic [BAR_W-1:0] base;
    logic [BAR_W-1:0] len;
  } bar_entry_t;

endpackage

// File: rtl/bar_decode.sv
module bar_decode
  import bar_scan_pkg::*;
#(
  parameter bit EXT16 = 1'b1
) (
  input  logic [BAR_W-1:0] sizing,
  input  logic [BAR_W-1:0] orig,
  output bar_space_e       space,
  output logic             ok,
  output logic             wide,
  output bar_entry_t       entry
);

  localparam logic [BAR_W-1:0] IO_KEEP  = ~((BAR_W)'((1 << IO_LOW_BITS) - 1));
  localparam logic [BAR_W-1:0] MEM_KEEP = ~((BAR_W)'((1 << MEM_LOW_BITS) - 1));

  logic [BAR_W-1:0] rb_ext;
  logic [BAR_W-1:0] keep;
  logic [BAR_W-1:0] inv;
  logic [BAR_W-1:0] len;

  // Optional widening of a readback that only answers in its lower half
  generate
    if (EXT16) begin : g_ext
      always_comb begin
        rb_ext = sizing;
        if (orig[0] && (sizing[BAR_W-1:HALF_W] == '0) && (sizing[HALF_W-1:0] != '0))
          rb_ext[BAR_W-1:HALF_W] = '1;
      end
    end else begin : g_no_ext
      assign rb_ext = sizing;
    end
  endgenerate

  always_comb begin
    space = orig[0] ? SPACE_IO : SPACE_MEM;
    keep  = orig[0] ? IO_KEEP : MEM_KEEP;
    inv   = ~(rb_ext & keep);
    len   = inv + 1'b1;
    ok    = (rb_ext != '0) && (rb_ext != '1) && ((len & inv) == '0);
    wide  = !orig[0] && (orig[2:0] == MEM64_TYPE);
    entry.base = orig & keep;
    entry.len  = len;
  end

endmodule

// File: rtl/bar_list.sv
module bar_list
  import bar_scan_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  bar_entry_t       wr_entry,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output bar_entry_t       rd_entry
);

  localparam int SLOTS = 1 << IDX_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  bar_entry_t       store [SLOTS];
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en;

  always_comb begin
    wr_idx = clear ? '0 : IDX_W'(count);
    wr_en  = push && (clear || (count < FULL));
  end

  // Storage without reset so that it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en)
      store[wr_idx] <= wr_entry;
    rd_entry <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= push ? CNT_W'(1) : '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (count < FULL)
        count <= count + 1'b1;
      else
        ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/bar_size_scan.sv
module bar_size_scan
  import bar_scan_pkg::*;
#(
  parameter int  LIST_DEPTH = 6,
  parameter bit  EXT16      = 1'b1,
  localparam int CNT_W      = $clog2(LIST_DEPTH + 1),
  localparam int IDX_W      = (LIST_DEPTH > 1) ? $clog2(LIST_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BAR_W-1:0] in_sizing,
  input  logic [BAR_W-1:0] in_orig,
  input  logic             in_last,
  output logic             scan_done,
  output logic [CNT_W-1:0] io_count,
  output logic             io_overflow,
  output logic [CNT_W-1:0] mem_count,
  output logic             mem_overflow,
  input  logic [IDX_W-1:0] io_rd_idx,
  output logic [BAR_W-1:0] io_rd_base,
  output logic [BAR_W-1:0] io_rd_len,
  input  logic [IDX_W-1:0] mem_rd_idx,
  output logic [BAR_W-1:0] mem_rd_base,
  output logic [BAR_W-1:0] mem_rd_len
);

  bar_space_e dec_space;
  logic       dec_ok;
  logic       dec_wide;
  bar_entry_t dec_entry;

  logic       accept;
  logic       take;
  logic       scan_open;
  logic       skip_pend;

  logic       s_vld;
  logic       s_first;
  logic       s_last;
  logic       s_push_io;
  logic       s_push_mem;
  bar_entry_t s_entry;

  bar_entry_t io_rd_entry;
  bar_entry_t mem_rd_entry;

  assign in_ready = 1'b1;
  assign accept   = in_valid;
  assign take     = !skip_pend;

  bar_decode #(.EXT16(EXT16)) u_decode (
    .sizing (in_sizing),
    .orig   (in_orig),
    .space  (dec_space),
    .ok     (dec_ok),
    .wide   (dec_wide),
    .entry  (dec_entry)
  );

  // Decode stage: one register between the arithmetic and the lists
  always_ff @(posedge clk) begin
    if (rst) begin
      s_vld      <= 1'b0;
      s_first    <= 1'b0;
      s_last     <= 1'b0;
      s_push_io  <= 1'b0;
      s_push_mem <= 1'b0;
      scan_open  <= 1'b0;
      skip_pend  <= 1'b0;
      scan_done  <= 1'b0;
    end else begin
      s_vld     <= accept;
      scan_done <= s_vld && s_last;
      if (accept) begin
        s_first    <= !scan_open;
        s_last     <= in_last;
        s_push_io  <= take && dec_ok && (dec_space == SPACE_IO);
        s_push_mem <= take && dec_ok && (dec_space == SPACE_MEM);
        skip_pend  <= take && dec_ok && dec_wide && !in_last;
        scan_open  <= !in_last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept)
      s_entry <= dec_entry;
  end

  bar_list #(.DEPTH(LIST_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_io_list (
    .clk      (clk),
    .rst      (rst),
    .clear    (s_vld && s_first),
    .push     (s_vld && s_push_io),
    .wr_entry (s_entry),
    .rd_idx   (io_rd_idx),
    .count    (io_count),
    .ovf      (io_overflow),
    .rd_entry (io_rd_entry)
  );

  bar_list #(.DEPTH(LIST_DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_mem_list (
    .clk      (clk),
    .rst      (rst),
    .clear    (s_vld && s_first),
    .push     (s_vld && s_push_mem),
    .wr_entry (s_entry),
    .rd_idx   (mem_rd_idx),
    .count    (mem_count),
    .ovf      (mem_overflow),
    .rd_entry (mem_rd_entry)
  );

  assign io_rd_base  = io_rd_entry.base;
  assign io_rd_len   = io_rd_entry.len;
  assign mem_rd_base = mem_rd_entry.base;
  assign mem_rd_len  = mem_rd_entry.len;

endmodule

// File: rtl/bar_size_scan_chk.sv
module bar_size_scan_chk #(
  parameter int  LIST_DEPTH = 6,
  localparam int CNT_W      = $clog2(LIST_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic             scan_done,
  input logic [CNT_W-1:0] io_count,
  input logic             io_overflow,
  input logic [CNT_W-1:0] mem_count,
  input logic             mem_overflow
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(LIST_DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  assert_io_bound_R7: assert property (@(posedge clk) disable iff (rst)
    io_count <= FULL);
  assert_mem_bound_R7: assert property (@(posedge clk) disable iff (rst)
    mem_count <= FULL);

  assert_io_ovf_full_R7: assert property (@(posedge clk) disable iff (rst)
    io_overflow |-> io_count == FULL);
  assert_mem_ovf_full_R7: assert property (@(posedge clk) disable iff (rst)
    mem_overflow |-> mem_count == FULL);

  assert_io_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(io_overflow) |-> io_count <= ONE);
  assert_mem_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_overflow) |-> mem_count <= ONE);

  assert_io_step_R8: assert property (@(posedge clk) disable iff (rst)
    (io_count != $past(io_count)) |->
      (((io_count - $past(io_count)) == ONE) || (io_count <= ONE)));
  assert_mem_step_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_count != $past(mem_count)) |->
      (((mem_count - $past(mem_count)) == ONE) || (mem_count <= ONE)));

  assert_io_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (io_count != $past(io_count)) |-> $past(in_valid, 2));
  assert_mem_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_count != $past(mem_count)) |-> $past(in_valid, 2));

  assert_done_cause_R9: assert property (@(posedge clk) disable iff (rst)
    scan_done |-> $past(in_valid && in_last, 2));

endmodule

bind bar_size_scan bar_size_scan_chk #(.LIST_DEPTH(LIST_DEPTH)) u_bar_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_last      (in_last),
  .scan_done    (scan_done),
  .io_count     (io_count),
  .io_overflow  (io_overflow),
  .mem_count    (mem_count),
  .mem_overflow (mem_overflow)
);

// File: tb/test_bar_size_scan.sv
module test_bar_size_scan;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int IDX_W      = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [31:0]      in_sizing = '0;
  logic [31:0]      in_orig = '0;
  logic             in_last = 1'b0;
  logic             scan_done;
  logic [CNT_W-1:0] io_count, mem_count;
  logic             io_overflow, mem_overflow;
  logic [IDX_W-1:0] io_rd_idx = '0, mem_rd_idx = '0;
  logic [31:0]      io_rd_base, io_rd_len, mem_rd_base, mem_rd_len;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bar_size_scan #(.LIST_DEPTH(DEPTH)) i_bar_size_scan (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sizing(in_sizing), .in_orig(in_orig), .in_last(in_last),
    .scan_done(scan_done), .io_count(io_count), .io_overflow(io_overflow),
    .mem_count(mem_count), .mem_overflow(mem_overflow),
    .io_rd_idx(io_rd_idx), .io_rd_base(io_rd_base), .io_rd_len(io_rd_len),
    .mem_rd_idx(mem_rd_idx), .mem_rd_base(mem_rd_base), .mem_rd_len(mem_rd_len)
  );

  int n_checks = 0;
  int n_errors = 0;

  // Expected-state model built from the requirements
  logic [31:0] m_io_base [DEPTH];
  logic [31:0] m_io_len  [DEPTH];
  logic [31:0] m_mem_base[DEPTH];
  logic [31:0] m_mem_len [DEPTH];
  int m_io_cnt = 0, m_mem_cnt = 0;
  bit m_io_ovf = 0, m_mem_ovf = 0, m_open = 0, m_skip = 0;

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic model_beat(input logic [31:0] rb, input logic [31:0] orig, input bit last);
    logic [31:0] ext, keep, inv, len;
    bit io, ok;
    if (!m_open) begin
      m_io_cnt = 0; m_mem_cnt = 0; m_io_ovf = 0; m_mem_ovf = 0;
    end
    m_open = !last;
    if (m_skip) begin
      m_skip = 0;
      return;
    end
    io  = orig[0];
    ext = rb;
    if (io && rb[31:16] == 16'h0 && rb[15:0] != 16'h0) ext[31:16] = 16'hFFFF;
    keep = io ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
    inv  = ~(ext & keep);
    len  = inv + 32'd1;
    ok   = (ext != 32'h0) && (ext != 32'hFFFF_FFFF) && ((len & inv) == 32'h0);
    if (ok) begin
      if (io) begin
        if (m_io_cnt < DEPTH) begin
          m_io_base[m_io_cnt] = orig & keep; m_io_len[m_io_cnt] = len; m_io_cnt++;
        end else m_io_ovf = 1;
      end else begin
        if (m_mem_cnt < DEPTH) begin
          m_mem_base[m_mem_cnt] = orig & keep; m_mem_len[m_mem_cnt] = len; m_mem_cnt++;
        end else m_mem_ovf = 1;
      end
    end
    m_skip = ok && !io && (orig[2:0] == 3'b100) && !last;
  endtask

  task automatic beat(input logic [31:0] rb, input logic [31:0] orig, input bit last);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sizing = rb;
    in_orig   = orig;
    in_last   = last;
    model_beat(rb, orig, last);
  endtask

  task automatic finish_scan(input string tag);
    int top;
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(negedge clk);
    check({tag, " R9 scan_done high"}, 32'(scan_done), 32'd1);
    check({tag, " R1 R3 io_count"}, 32'(io_count), 32'(m_io_cnt));
    check({tag, " R1 R3 mem_count"}, 32'(mem_count), 32'(m_mem_cnt));
    check({tag, " R7 io_overflow"}, 32'(io_overflow), 32'(m_io_ovf));
    check({tag, " R7 mem_overflow"}, 32'(mem_overflow), 32'(m_mem_ovf));
    @(negedge clk);
    check({tag, " R9 scan_done pulse ends"}, 32'(scan_done), 32'd0);
    top = (m_io_cnt > m_mem_cnt) ? m_io_cnt : m_mem_cnt;
    for (int i = 0; i < top; i++) begin
      io_rd_idx  = IDX_W'(i);
      mem_rd_idx = IDX_W'(i);
      @(negedge clk);
      if (i < m_io_cnt) begin
        check($sformatf("%s R4 R10 io base %0d", tag, i), io_rd_base, m_io_base[i]);
        check($sformatf("%s R2 R10 io len %0d", tag, i), io_rd_len, m_io_len[i]);
      end
      if (i < m_mem_cnt) begin
        check($sformatf("%s R4 R10 mem base %0d", tag, i), mem_rd_base, m_mem_base[i]);
        check($sformatf("%s R2 R10 mem len %0d", tag, i), mem_rd_len, m_mem_len[i]);
      end
    end
  endtask

  function automatic logic [31:0] io_orig_of(input int k);
    return (32'h9E37_79B9 * 32'(k)) | 32'h1;
  endfunction

  function automatic logic [31:0] mem_orig_of(input int k);
    logic [31:0] v;
    v = (32'h7F4A_7C15 * 32'(k)) & 32'hFFFF_FFF0;
    v[3] = k[1];
    v[1] = k[0];
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11 io_count in reset", 32'(io_count), 32'd0);
    check("R11 mem_count in reset", 32'(mem_count), 32'd0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 io_count after reset", 32'(io_count), 32'd0);
    check("R11 mem_count after reset", 32'(mem_count), 32'd0);
    check("R11 io_overflow after reset", 32'(io_overflow), 32'd0);
    check("R11 mem_overflow after reset", 32'(mem_overflow), 32'd0);
    check("R11 scan_done after reset", 32'(scan_done), 32'd0);
    check("R10 in_ready", 32'(in_ready), 32'd1);

    // R1 R2 R4: sweep every power-of-two size for both spaces
    for (int k0 = 2; k0 <= 31; k0 += 3) begin
      for (int k = k0; k < k0 + 3 && k <= 31; k++) begin
        beat(~((32'd1 << k) - 32'd1) | 32'h1, io_orig_of(k), 1'b0);
        if (k >= 4)
          beat(~((32'd1 << k) - 32'd1) | (mem_orig_of(k) & 32'hF), mem_orig_of(k), 1'b0);
      end
      beat(32'h0, 32'h0000_0001, 1'b1);
      finish_scan("sweep");
    end

    // R5 R3 R2: widening, malformed masks, wrap-around length
    beat(32'h0000_FFF1, 32'h0000_C001, 1'b0);
    beat(32'h0000_FF01, 32'h0000_D103, 1'b0);
    beat(32'hFFFF_FFFF, 32'h0000_E001, 1'b0);
    beat(32'hFFF0_F001, 32'h0000_F001, 1'b0);
    beat(32'h0000_FFF0, 32'h1000_0000, 1'b0);
    beat(32'h0000_000C, 32'h2000_000C, 1'b1);
    finish_scan("R5 R3");
    io_rd_idx = '0;
    @(negedge clk);
    check("R5 widened io len", io_rd_len, 32'h0000_0010);
    check("R5 io_count", 32'(io_count), 32'd2);
    check("R2 wrap mem_count", 32'(mem_count), 32'd1);

    // R6: 64-bit skip, no skip after an invalid 64-bit slot, skip at last beat
    beat(32'hFFF0_0004, 32'h8000_0004, 1'b0);
    beat(32'hFFFF_FF01, 32'h0000_1001, 1'b0);
    beat(32'hFFFF_FF01, 32'h0000_2001, 1'b0);
    beat(32'h0000_0000, 32'h4000_0004, 1'b0);
    beat(32'hFFFF_FFE1, 32'h0000_3001, 1'b0);
    beat(32'hFFFF_000C, 32'h9000_000C, 1'b1);
    finish_scan("R6");
    check("R6 io_count", 32'(io_count), 32'd2);
    check("R6 mem_count", 32'(mem_count), 32'd2);

    // R7 R8: new scan starts clean, first beat not skipped, I/O overflow
    for (int i = 0; i < 8; i++)
      beat(32'hFFFF_FFF1, 32'h0000_0101 + 32'(i) * 32'h100, 1'b0);
    beat(32'hFFFF_F000, 32'hA000_0000, 1'b1);
    finish_scan("R7 R8");
    check("R7 io_count full", 32'(io_count), 32'd6);
    check("R7 io_overflow set", 32'(io_overflow), 32'd1);
    check("R7 mem_overflow clear", 32'(mem_overflow), 32'd0);

    // R8: results hold between scans, then a fresh scan clears them
    repeat (5) @(negedge clk);
    check("R8 io_count held", 32'(io_count), 32'd6);
    check("R8 io_overflow held", 32'(io_overflow), 32'd1);
    beat(32'hFFFF_FFF0, 32'h1234_5678, 1'b1);
    finish_scan("R8");
    check("R8 io_count cleared", 32'(io_count), 32'd0);
    check("R8 io_overflow cleared", 32'(io_overflow), 32'd0);

    // R3: a scan with nothing valid
    beat(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    beat(32'hFFF0_F001, 32'h0000_0001, 1'b0);
    beat(32'h0000_FFF0, 32'h0000_0000, 1'b1);
    finish_scan("R3 empty");
    check("R3 empty io_count", 32'(io_count), 32'd0);
    check("R3 empty mem_count", 32'(mem_count), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule